// File: doc/BRIEF.md
# USB Frame Timer with Done-Queue Interrupt Delay

This block keeps frame time for a full-speed USB host controller. While the controller is operational, it counts 12 MHz bit-time enables down from a programmable frame interval. Each time the count passes zero, the block emits a one-cycle start-of-frame pulse and advances a 16-bit frame number. It also reloads the count from the interval register and copies the interval toggle bit into the toggle bit of the remaining-time readback. A new interval takes effect only at that reload, so a frame already in progress keeps its length.

The same block holds the done-queue delay logic. Each retired transfer descriptor becomes the new done-queue head. The descriptor's 3-bit delay value can lower a delay counter, which otherwise sits at 7. At frame boundaries the counter steps down. When it is found at zero and no writeback interrupt is pending, the block issues a writeback request that carries the head, then clears the head and rearms the counter.

The surrounding controller supplies the bit-time enable, the operational flag, register writes, descriptor retirements and two interrupt-pending flags. It consumes the readbacks, the start-of-frame pulse and the writeback request.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset the readbacks are as follows:
  - interval readback is 0x27782EDF (toggle 0, packet size 0x2778, interval 0x2EDF);
  - frame number is 0;
  - periodic start is 0;
  - low-speed threshold is 0x628;
  - remaining-time readback is 0;
  - delay counter is 7;
  - start-of-frame is 0 and writeback request is 0.
- R2: While `run_en` is high, each `bit_tick` lowers the remaining count by one. The low 14 bits of `remaining_rd` show the count. A frame lasts interval+1 ticks.
- R3: While `run_en` is low, the low bits of `remaining_rd` read 0 and the count is held at the interval value. Counting therefore starts from the interval on the first operational tick.
- R4: A tick that finds the count at zero is a frame boundary. On the following cycle:
  - `sof_pulse` is high for one cycle;
  - the frame number has grown by one modulo 2^16;
  - bit 31 of `remaining_rd` equals the interval toggle bit;
  - the count has reloaded from the interval.
- R5: A write with `reg_sel`=0 stores bit 31 as the toggle, bits 30:16 as the packet size and bits 13:0 as the interval. `interval_rd` returns those fields at the same positions with bits 15:14 zero. The frame in progress keeps counting, and the new interval is used from the next reload.
- R6: Writes with `reg_sel`=1 (periodic start) and `reg_sel`=2 (low-speed threshold) keep only the low 16 bits of `reg_wdata`. `reg_sel`=3 changes nothing.
- R7: A retire pulse makes `done_head` the retired address with bits 3:0 cleared. It lowers `delay_cnt` to `retire_delay` when that value is smaller, and leaves it unchanged otherwise.
- R8: At a frame boundary where the delay counter is 0 and `wd_pending` is low, the block acts on the next cycle:
  - `wb_req` is high for one cycle;
  - `wb_head` carries the head with bit 0 equal to `other_irq_pending`;
  - the head is cleared;
  - the counter is 7.
- R9: At a frame boundary where the delay counter is 0 and `wd_pending` is high, no writeback occurs and the counter stays 0.
- R10: At a frame boundary the counter decrements by one when it is between 1 and 6. It stays at 7 when at 7. It never changes without a boundary or a retire.
- R11: A retire in the same cycle as a frame boundary is applied before the boundary decision. Its address and delay take part in that boundary's writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One 12 MHz bit time has elapsed |
| run_en | input | 1 | Controller is in the operational state |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 interval, 1 periodic start, 2 low-speed threshold, 3 none |
| reg_wdata | input | 32 | Register write data |
| retire_vld | input | 1 | A descriptor retires this cycle |
| retire_delay | input | 3 | Delay value of the retiring descriptor |
| retire_addr | input | 32 | Address of the retiring descriptor |
| wd_pending | input | 1 | Writeback interrupt already pending |
| other_irq_pending | input | 1 | Some other enabled interrupt is pending |
| interval_rd | output | 32 | Interval register readback |
| remaining_rd | output | 32 | Toggle at bit 31, remaining bit times in low bits |
| frame_num | output | 16 | Frame number |
| pstart_rd | output | 16 | Periodic start readback |
| lsthr_rd | output | 16 | Low-speed threshold readback |
| sof_pulse | output | 1 | Start-of-frame, one cycle |
| wb_req | output | 1 | Done-head writeback request, one cycle |
| wb_head | output | 32 | Head value to write back, held until the next request |
| done_head | output | 32 | Accumulated done-queue head |
| delay_cnt | output | 3 | Interrupt-delay counter |

## Verification
The embedded properties watch these behaviours on every cycle:
- the one-step countdown and the idle reload (R2, R3);
- the frame number increment and the toggle copy at a boundary (R4);
- the delay counter never rising above a retired delay and holding when nothing touches it (R7, R10);
- a writeback never following a cycle with `wd_pending` high, and always leaving the counter at 7 with an empty head (R8, R9).

Some behaviours only the bench scenarios can show:
- deferral of a mid-frame interval write to the next reload (R5);
- the 16-bit frame number wrap (R4);
- the exact bit-0 marking of the written head (R8);
- ordering of a retire against a coincident boundary (R11);
- the field truncation of the register writes (R5, R6).

// File: rtl/usb_ft_pkg.sv
package usb_ft_pkg;

   typedef enum logic [1:0] {
      FT_SEL_INTERVAL = 2'd0,
      FT_SEL_PSTART   = 2'd1,
      FT_SEL_LSTHR    = 2'd2,
      FT_SEL_NONE     = 2'd3
   } ft_sel_e;

   localparam int unsigned FT_FIT_BIT   = 31;
   localparam int unsigned FT_MPS_LSB   = 16;
   localparam int unsigned FT_ALIGN_LOG = 4;

   localparam logic [31:0] FT_FI_RST    = 32'h0000_2EDF;
   localparam logic [31:0] FT_MPS_RST   = 32'h0000_2778;
   localparam logic [31:0] FT_PSTART_RST = 32'h0000_0000;
   localparam logic [31:0] FT_LSTHR_RST = 32'h0000_0628;

endpackage

// File: rtl/ft_regs.sv
module ft_regs
   import usb_ft_pkg::*;
#(
   parameter int FI_W  = 14,
   parameter int MPS_W = 15,
   parameter int THR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [1:0]       sel_i,
   input  logic [31:0]      wdata_i,
   output logic [FI_W-1:0]  fi_o,
   output logic [MPS_W-1:0] mps_o,
   output logic             fit_o,
   output logic [THR_W-1:0] pstart_o,
   output logic [THR_W-1:0] lsthr_o,
   output logic [31:0]      interval_rd_o
);

   localparam int N_THR = 2;
   localparam logic [N_THR-1:0][31:0] THR_RST = {FT_LSTHR_RST, FT_PSTART_RST};

   logic [FI_W-1:0]  fi_q;
   logic [MPS_W-1:0] mps_q;
   logic             fit_q;
   logic [N_THR-1:0][THR_W-1:0] thr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fi_q  <= FT_FI_RST[FI_W-1:0];
         mps_q <= FT_MPS_RST[MPS_W-1:0];
         fit_q <= 1'b0;
      end else if (wr_i && ft_sel_e'(sel_i) == FT_SEL_INTERVAL) begin
         fi_q  <= wdata_i[FI_W-1:0];
         mps_q <= wdata_i[FT_MPS_LSB +: MPS_W];
         fit_q <= wdata_i[FT_FIT_BIT];
      end
   end

   // the two 16-bit threshold registers share one structure
   for (genvar g = 0; g < N_THR; g++) begin : g_thr
      localparam logic [1:0] MY_SEL = (g == 0) ? FT_SEL_PSTART : FT_SEL_LSTHR;
      always_ff @(posedge clk) begin
         if (!rst_n)
            thr_q[g] <= THR_RST[g][THR_W-1:0];
         else if (wr_i && sel_i == MY_SEL)
            thr_q[g] <= wdata_i[THR_W-1:0];
      end
   end

   always_comb begin
      interval_rd_o                         = '0;
      interval_rd_o[FT_FIT_BIT]             = fit_q;
      interval_rd_o[FT_MPS_LSB +: MPS_W]    = mps_q;
      interval_rd_o[FI_W-1:0]               = fi_q;
   end

   assign fi_o     = fi_q;
   assign mps_o    = mps_q;
   assign fit_o    = fit_q;
   assign pstart_o = thr_q[0];
   assign lsthr_o  = thr_q[1];

   // R5: interval fields land where the write put them
   p_interval_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && sel_i == 2'd0) |=> (interval_rd_o[FI_W-1:0] == $past(wdata_i[FI_W-1:0]))
                                   && (fit_o == $past(wdata_i[31])));

endmodule

// File: rtl/ft_countdown.sv
module ft_countdown #(
   parameter int FI_W = 14,
   parameter int FN_W = 16,
   parameter logic [FI_W-1:0] FI_RST = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick_i,
   input  logic            run_i,
   input  logic [FI_W-1:0] fi_i,
   input  logic            fit_i,
   output logic [FI_W-1:0] rem_o,
   output logic            frt_o,
   output logic [FN_W-1:0] fn_o,
   output logic            sof_o,
   output logic            edge_o
);

   logic [FI_W-1:0] rem_q;
   logic            frt_q;
   logic [FN_W-1:0] fn_q;
   logic            sof_q;

   assign edge_o = run_i && tick_i && (rem_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q <= FI_RST;
         frt_q <= 1'b0;
         fn_q  <= '0;
         sof_q <= 1'b0;
      end else begin
         sof_q <= edge_o;
         if (!run_i) begin
            rem_q <= fi_i;
         end else if (tick_i) begin
            if (rem_q == '0) begin
               rem_q <= fi_i;
               frt_q <= fit_i;
               fn_q  <= fn_q + FN_W'(1);
            end else begin
               rem_q <= rem_q - FI_W'(1);
            end
         end
      end
   end

   assign rem_o = rem_q;
   assign frt_o = frt_q;
   assign fn_o  = fn_q;
   assign sof_o = sof_q;

   p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && tick_i && rem_q != '0) |=> rem_q == $past(rem_q) - FI_W'(1));

   p_idle_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i) |=> rem_q == $past(fi_i));

   p_fn_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o |=> (fn_q == $past(fn_q) + FN_W'(1)) && sof_q);

   p_toggle_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o |=> frt_q == $past(fit_i));

endmodule

// File: rtl/ft_done_delay.sv
module ft_done_delay
   import usb_ft_pkg::*;
#(
   parameter int DLY_W  = 3,
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              edge_i,
   input  logic              retire_vld_i,
   input  logic [DLY_W-1:0]  retire_dly_i,
   input  logic [ADDR_W-1:0] retire_addr_i,
   input  logic              wd_pend_i,
   input  logic              oth_pend_i,
   output logic [DLY_W-1:0]  dly_o,
   output logic [ADDR_W-1:0] head_o,
   output logic              wb_req_o,
   output logic [ADDR_W-1:0] wb_head_o
);

   localparam logic [DLY_W-1:0]  DLY_MAX    = '1;
   localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'((1 << FT_ALIGN_LOG) - 1);

   logic [DLY_W-1:0]  dly_q, dly_eff;
   logic [ADDR_W-1:0] head_q, head_eff, wbh_q;
   logic              wb_q, fire;

   // a retire in the boundary cycle counts before the boundary decision
   always_comb begin
      dly_eff  = dly_q;
      head_eff = head_q;
      if (retire_vld_i) begin
         head_eff = retire_addr_i & ALIGN_MASK;
         if (retire_dly_i < dly_q)
            dly_eff = retire_dly_i;
      end
      fire = edge_i && (dly_eff == '0) && !wd_pend_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dly_q  <= DLY_MAX;
         head_q <= '0;
         wb_q   <= 1'b0;
         wbh_q  <= '0;
      end else begin
         wb_q <= fire;
         if (fire) begin
            wbh_q  <= head_eff | ADDR_W'(oth_pend_i);
            head_q <= '0;
            dly_q  <= DLY_MAX;
         end else begin
            head_q <= head_eff;
            if (edge_i && dly_eff != '0 && dly_eff != DLY_MAX)
               dly_q <= dly_eff - DLY_W'(1);
            else
               dly_q <= dly_eff;
         end
      end
   end

   assign dly_o     = dly_q;
   assign head_o    = head_q;
   assign wb_req_o  = wb_q;
   assign wb_head_o = wbh_q;

   p_dly_lower_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (retire_vld_i && !edge_i) |=> dly_q <= $past(retire_dly_i));

   p_wb_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wb_q |-> (dly_q == DLY_MAX) && (head_q == '0));

   p_wb_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wb_q |-> $past(wd_pend_i) == 1'b0);

   p_dly_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_i && !retire_vld_i) |=> $stable(dly_q));

endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
   import usb_ft_pkg::*;
#(
   parameter int FI_W   = 14,
   parameter int MPS_W  = 15,
   parameter int FN_W   = 16,
   parameter int THR_W  = 16,
   parameter int DLY_W  = 3,
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              run_en,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [31:0]       reg_wdata,
   input  logic              retire_vld,
   input  logic [DLY_W-1:0]  retire_delay,
   input  logic [ADDR_W-1:0] retire_addr,
   input  logic              wd_pending,
   input  logic              other_irq_pending,
   output logic [31:0]       interval_rd,
   output logic [31:0]       remaining_rd,
   output logic [FN_W-1:0]   frame_num,
   output logic [THR_W-1:0]  pstart_rd,
   output logic [THR_W-1:0]  lsthr_rd,
   output logic              sof_pulse,
   output logic              wb_req,
   output logic [ADDR_W-1:0] wb_head,
   output logic [ADDR_W-1:0] done_head,
   output logic [DLY_W-1:0]  delay_cnt
);

   initial begin
      assert (FI_W >= 1 && FI_W <= 14) else $error("FI_W must fit bits 13:0");
      assert (MPS_W >= 1 && MPS_W <= 15) else $error("MPS_W must fit bits 30:16");
      assert (THR_W >= 1 && THR_W <= 16) else $error("THR_W must be at most 16");
      assert (FN_W >= 1 && FN_W <= 32) else $error("FN_W out of range");
      assert (DLY_W >= 1 && DLY_W <= 8) else $error("DLY_W out of range");
      assert (ADDR_W > FT_ALIGN_LOG) else $error("ADDR_W too small");
   end

   logic [FI_W-1:0]  fi;
   logic [MPS_W-1:0] mps;
   logic             fit;
   logic [FI_W-1:0]  rem;
   logic             frt;
   logic             frame_edge;

   ft_regs #(.FI_W(FI_W), .MPS_W(MPS_W), .THR_W(THR_W)) u_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_i          (reg_wr),
      .sel_i         (reg_sel),
      .wdata_i       (reg_wdata),
      .fi_o          (fi),
      .mps_o         (mps),
      .fit_o         (fit),
      .pstart_o      (pstart_rd),
      .lsthr_o       (lsthr_rd),
      .interval_rd_o (interval_rd)
   );

   ft_countdown #(.FI_W(FI_W), .FN_W(FN_W), .FI_RST(FT_FI_RST[FI_W-1:0])) u_count (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (bit_tick),
      .run_i  (run_en),
      .fi_i   (fi),
      .fit_i  (fit),
      .rem_o  (rem),
      .frt_o  (frt),
      .fn_o   (frame_num),
      .sof_o  (sof_pulse),
      .edge_o (frame_edge)
   );

   ft_done_delay #(.DLY_W(DLY_W), .ADDR_W(ADDR_W)) u_delay (
      .clk           (clk),
      .rst_n         (rst_n),
      .edge_i        (frame_edge),
      .retire_vld_i  (retire_vld),
      .retire_dly_i  (retire_delay),
      .retire_addr_i (retire_addr),
      .wd_pend_i     (wd_pending),
      .oth_pend_i    (other_irq_pending),
      .dly_o         (delay_cnt),
      .head_o        (done_head),
      .wb_req_o      (wb_req),
      .wb_head_o     (wb_head)
   );

   always_comb begin
      remaining_rd              = '0;
      remaining_rd[FT_FIT_BIT]  = frt;
      if (run_en)
         remaining_rd[FI_W-1:0] = rem;
   end

   // R8: a writeback only ever accompanies a start-of-frame
   p_wb_with_sof_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req |-> sof_pulse);

   // R3: idle readback low bits stay clear across cycles
   p_idle_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && $past(!run_en)) |-> remaining_rd[FI_W-1:0] == '0);

   logic unused_mps;
   assign unused_mps = ^mps;

endmodule

// File: tb/usb_frame_timer_bench.sv
`timescale 1ns/1ps
module usb_frame_timer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0, run = 1'b0, we = 1'b0;
   logic [1:0]  sel = 2'd3;
   logic [31:0] wd = '0;
   logic        rv = 1'b0;
   logic [2:0]  rd = '0;
   logic [31:0] ra = '0;
   logic        wdp = 1'b0, oth = 1'b0;

   logic [31:0] interval_rd, remaining_rd, wb_head, done_head;
   logic [15:0] frame_num, pstart_rd, lsthr_rd;
   logic        sof_pulse, wb_req;
   logic [2:0]  delay_cnt;

   int total = 0, bad = 0;
   bit finished = 0;

   // bench model state
   logic [13:0] m_fi, m_rem;
   logic [14:0] m_mps;
   logic        m_fit, m_frt, m_sof, m_wb;
   logic [15:0] m_fn, m_ps, m_ls;
   logic [2:0]  m_dly;
   logic [31:0] m_head, m_wbh;

   always #2.5 clk = ~clk;

   usb_frame_timer u_usb_frame_timer (
      .clk(clk), .rst_n(rst_n), .bit_tick(tick), .run_en(run),
      .reg_wr(we), .reg_sel(sel), .reg_wdata(wd),
      .retire_vld(rv), .retire_delay(rd), .retire_addr(ra),
      .wd_pending(wdp), .other_irq_pending(oth),
      .interval_rd(interval_rd), .remaining_rd(remaining_rd), .frame_num(frame_num),
      .pstart_rd(pstart_rd), .lsthr_rd(lsthr_rd), .sof_pulse(sof_pulse),
      .wb_req(wb_req), .wb_head(wb_head), .done_head(done_head), .delay_cnt(delay_cnt)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_init();
      m_fi = 14'h2EDF; m_rem = 14'h2EDF; m_mps = 15'h2778; m_fit = 0; m_frt = 0;
      m_sof = 0; m_wb = 0; m_fn = 0; m_ps = 0; m_ls = 16'h0628;
      m_dly = 3'd7; m_head = 0; m_wbh = 0;
   endtask

   task automatic model_step();
      logic [2:0]  de;
      logic [31:0] he;
      logic        bnd;
      de = m_dly; he = m_head;
      if (rv) begin
         he = ra & 32'hFFFF_FFF0;
         if (rd < m_dly) de = rd;
      end
      bnd = run && tick && (m_rem == 14'd0);
      m_sof = bnd;
      m_wb  = 1'b0;
      if (bnd && de == 3'd0 && !wdp) begin
         m_wb = 1'b1; m_wbh = he | {31'd0, oth}; m_head = 0; m_dly = 3'd7;
      end else begin
         m_head = he;
         m_dly  = (bnd && de != 3'd0 && de != 3'd7) ? de - 3'd1 : de;
      end
      if (!run) m_rem = m_fi;
      else if (tick) begin
         if (m_rem == 14'd0) begin
            m_rem = m_fi; m_frt = m_fit; m_fn = m_fn + 16'd1;
         end else m_rem = m_rem - 14'd1;
      end
      if (we) begin
         case (sel)
            2'd0: begin m_fi = wd[13:0]; m_mps = wd[30:16]; m_fit = wd[31]; end
            2'd1: m_ps = wd[15:0];
            2'd2: m_ls = wd[15:0];
            default: ;
         endcase
      end
   endtask

   task automatic compare_all();
      chk("R5 interval", interval_rd, {m_fit, m_mps, 2'b00, m_fi});
      chk("R2 remaining", remaining_rd, {m_frt, 17'd0, (run ? m_rem : 14'd0)});
      chk("R4 frame", {16'd0, frame_num}, {16'd0, m_fn});
      chk("R4 sof", {31'd0, sof_pulse}, {31'd0, m_sof});
      chk("R6 pstart", {16'd0, pstart_rd}, {16'd0, m_ps});
      chk("R6 lsthr", {16'd0, lsthr_rd}, {16'd0, m_ls});
      chk("R7 delay", {29'd0, delay_cnt}, {29'd0, m_dly});
      chk("R7 head", done_head, m_head);
      chk("R8 wbreq", {31'd0, wb_req}, {31'd0, m_wb});
      chk("R8 wbhead", wb_head, m_wbh);
   endtask

   // one clock: model advances on the driven inputs, outputs compared at the next falling edge
   task automatic cycle();
      model_step();
      @(posedge clk);
      @(negedge clk);
      compare_all();
      we = 1'b0; rv = 1'b0;
   endtask

   task automatic wr(input logic [1:0] s, input logic [31:0] d);
      we = 1'b1; sel = s; wd = d;
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      int seed_v;
      logic [15:0] fn0;
      seed_v = $urandom(32'h5EED_0042);
      model_init();
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 interval", interval_rd, 32'h2778_2EDF);
      chk("R1 frame", {16'd0, frame_num}, 32'd0);
      chk("R1 pstart", {16'd0, pstart_rd}, 32'd0);
      chk("R1 lsthr", {16'd0, lsthr_rd}, 32'h628);
      chk("R1 remaining", remaining_rd, 32'd0);
      chk("R1 delay", {29'd0, delay_cnt}, 32'd7);
      chk("R1 sof", {31'd0, sof_pulse}, 32'd0);
      chk("R1 wbreq", {31'd0, wb_req}, 32'd0);

      // R5 write while idle, R3 idle readback
      wr(2'd0, 32'h8000_0005); cycle();
      chk("R5 fields", interval_rd, 32'h8000_0005);
      tick = 1'b1;
      for (int i = 0; i < 3; i++) begin
         cycle();
         chk("R3 idle zero", remaining_rd, 32'd0);
      end

      // R2 countdown and R4 boundary
      run = 1'b1;
      cycle();
      chk("R2 first tick", remaining_rd, 32'd4);
      for (int i = 0; i < 4; i++) cycle();
      chk("R2 at zero", remaining_rd, 32'd0);
      chk("R2 no sof yet", {31'd0, sof_pulse}, 32'd0);
      cycle();
      chk("R4 sof", {31'd0, sof_pulse}, 32'd1);
      chk("R4 frame", {16'd0, frame_num}, 32'd1);
      chk("R4 toggle+reload", remaining_rd, 32'h8000_0005);

      // R5 mid-frame write deferred
      wr(2'd0, 32'h0000_0002); cycle();
      chk("R5 old frame continues", remaining_rd, 32'h8000_0004);
      for (int i = 0; i < 5; i++) cycle();
      chk("R5 new reload", remaining_rd, 32'h0000_0002);
      chk("R5 sof", {31'd0, sof_pulse}, 32'd1);

      // interval 0: every tick becomes a boundary
      tick = 1'b0;
      wr(2'd0, 32'h0000_0000); cycle();
      tick = 1'b1;
      for (int i = 0; i < 3; i++) cycle();
      tick = 1'b0;

      // R7 retire lowering
      rv = 1'b1; rd = 3'd3; ra = 32'h0000_0123; cycle();
      chk("R7 lowered", {29'd0, delay_cnt}, 32'd3);
      chk("R7 head", done_head, 32'h0000_0120);
      rv = 1'b1; rd = 3'd5; ra = 32'h0000_0200; cycle();
      chk("R7 not raised", {29'd0, delay_cnt}, 32'd3);
      chk("R7 head new", done_head, 32'h0000_0200);

      // R10 decrement
      tick = 1'b1;
      cycle(); chk("R10 dec", {29'd0, delay_cnt}, 32'd2);
      cycle(); chk("R10 dec", {29'd0, delay_cnt}, 32'd1);
      cycle(); chk("R10 dec", {29'd0, delay_cnt}, 32'd0);
      // R9 blocked by pending writeback interrupt
      wdp = 1'b1; cycle();
      chk("R9 no wb", {31'd0, wb_req}, 32'd0);
      chk("R9 stays 0", {29'd0, delay_cnt}, 32'd0);
      // R8 writeback with other-interrupt mark
      wdp = 1'b0; oth = 1'b1; cycle();
      chk("R8 wbreq", {31'd0, wb_req}, 32'd1);
      chk("R8 wbhead", wb_head, 32'h0000_0201);
      chk("R8 reload", {29'd0, delay_cnt}, 32'd7);
      chk("R8 head clear", done_head, 32'd0);
      oth = 1'b0; cycle();
      chk("R10 hold 7", {29'd0, delay_cnt}, 32'd7);
      chk("R8 one cycle", {31'd0, wb_req}, 32'd0);
      // R11 retire coinciding with a boundary
      rv = 1'b1; rd = 3'd0; ra = 32'h0000_0345; cycle();
      chk("R11 wbreq", {31'd0, wb_req}, 32'd1);
      chk("R11 wbhead", wb_head, 32'h0000_0340);
      chk("R11 delay", {29'd0, delay_cnt}, 32'd7);

      // R6 threshold truncation, sel 3 inert
      wr(2'd1, 32'hABCD_1234); cycle();
      chk("R6 pstart", {16'd0, pstart_rd}, 32'h1234);
      wr(2'd2, 32'h5A5A_9876); cycle();
      chk("R6 lsthr", {16'd0, lsthr_rd}, 32'h9876);
      wr(2'd3, 32'hFFFF_FFFF); cycle();
      chk("R6 none", {16'd0, lsthr_rd}, 32'h9876);
      chk("R6 none intv", interval_rd, 32'h0000_0000);

      // R4 frame number wrap
      fn0 = frame_num;
      for (int i = 0; i < 65536; i++) cycle();
      chk("R4 wrap", {16'd0, frame_num}, {16'd0, fn0});

      // random phase
      for (int i = 0; i < 20000; i++) begin
         tick = ($urandom % 4) != 0;
         if (($urandom % 500) == 0) run = ~run;
         rv  = ($urandom % 8) == 0;
         rd  = 3'($urandom);
         ra  = $urandom;
         wdp = ($urandom % 5) == 0;
         oth = $urandom % 2;
         if (($urandom % 200) == 0) begin
            wr(2'($urandom), {$urandom} & 32'hFFFF_C000 | ($urandom % 40));
         end
         if (!run && ($urandom % 10) == 0) run = 1'b1;
         cycle();
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule